// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves a data word between two ports, A and B, through an independent storage path in each direction. Each path keeps one stored word and can pass data in four ways. It can be transparent, so that the output follows the input. It can hold its stored word. It can capture on an edge of its own direction clock. It can capture on that edge only when an active-low clock enable permits it. The latch enable of a path overrides its clock: while it is high, the path is transparent whatever the clock does.

The block runs on a core clock `clk`. The per-direction clocks are level inputs that the core clock samples, and a capture takes place at the core edge where a low-to-high change of that level is first seen. Each output is a data bus plus a drive flag. The flag is high when the direction's active-low output enable is low. At the chip edge the flag serves as the enable of a tri-state buffer. Storage keeps updating while a direction is not driving.

Top module: `bidir_regxcvr`

## Requirements
- R1: While `rst_n` is low, both stored words are zero and the edge history of each direction clock is taken as high, so a direction clock that is already high at reset release causes no capture.
- R2: While a direction's latch enable is high, its output equals its input in the same cycle, and the stored word takes the input at every core edge.
- R3: While the latch enable is low and no capture occurs, the output stays at the stored word whatever the input does.
- R4: When the latch enable falls, the output shows the input value sampled at the last core edge where the latch enable was still high.
- R5: With the latch enable low and the clock enable low, a core edge that sees the direction clock high after it was seen low stores the input. The output shows that value after the edge.
- R6: With the clock enable high (inactive), a rising direction clock stores nothing.
- R7: A falling direction clock stores nothing.
- R8: The drive flag of a direction is high exactly when its output enable is low.
- R9: The stored word updates while the drive flag is low. Enabling the output then shows the current stored word.
- R10: The two directions keep separate storage and controls. Activity on one never changes the other's output or drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_i | input | WIDTH | Data arriving on port A |
| a2b_oe_n | input | 1 | A-to-B output enable, active low |
| a2b_le | input | 1 | A-to-B latch enable, high = transparent |
| a2b_clk | input | 1 | A-to-B capture clock level |
| a2b_cken_n | input | 1 | A-to-B clock enable, active low |
| port_b_o | output | WIDTH | Data presented on port B |
| port_b_drive | output | 1 | Port B driver enable |
| port_b_i | input | WIDTH | Data arriving on port B |
| b2a_oe_n | input | 1 | B-to-A output enable, active low |
| b2a_le | input | 1 | B-to-A latch enable, high = transparent |
| b2a_clk | input | 1 | B-to-A capture clock level |
| b2a_cken_n | input | 1 | B-to-A clock enable, active low |
| port_a_o | output | WIDTH | Data presented on port A |
| port_a_drive | output | 1 | Port A driver enable |

## Verification
The hardest situation to reach is a change of the latch enable that coincides with a change of the input and with a direction clock edge. The priority of the latch enable and the value left behind when it falls can only be seen in that case. The stimulus drops the latch enable in the same cycle as a new data word and a clock toggle. It also raises the clock while the clock enable is inactive and lowers it while the enable is active, so that captures on the wrong edge or with the wrong enable are exposed. A reference model that runs in parallel checks both directions on every cycle, including while one direction is not driving.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   localparam int DIRS   = 2;
   localparam int DIR_AB = 0;
   localparam int DIR_BA = 1;

   // control bundle of one direction
   typedef struct packed {
      logic oe_n;
      logic le;
      logic clk_lvl;
      logic cken_n;
   } dir_ctrl_t;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   localparam logic PREV_RST = RISING;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PREV_RST;
      else        prev_q <= lvl;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = lvl & ~prev_q;
      end else begin : g_fall
         assign pulse = ~lvl & prev_q;
      end
   endgenerate
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             le,
   input  logic             cap,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] held_q;

   // latch enable takes precedence; both load the same word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= '0;
      else if (le || cap) held_q <= d;
   end

   assign q = le ? d : held_q;
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
   import xcvr_pkg::*;
#(
   parameter int WIDTH       = 18,
   parameter bit EDGE_RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dir_ctrl_t        ctl,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             drive
);
   logic edge_seen;
   logic cap;

   xcvr_edge_det #(.RISING(EDGE_RISING)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (ctl.clk_lvl),
      .pulse (edge_seen)
   );

   assign cap = edge_seen & ~ctl.cken_n;

   xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (ctl.le),
      .cap   (cap),
      .d     (din),
      .q     (dout)
   );

   assign drive = ~ctl.oe_n;
endmodule

// File: rtl/bidir_regxcvr.sv
module bidir_regxcvr
   import xcvr_pkg::*;
#(
   parameter int WIDTH       = 18,
   parameter bit EDGE_RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] port_a_i,
   input  logic             a2b_oe_n,
   input  logic             a2b_le,
   input  logic             a2b_clk,
   input  logic             a2b_cken_n,
   output logic [WIDTH-1:0] port_b_o,
   output logic             port_b_drive,
   input  logic [WIDTH-1:0] port_b_i,
   input  logic             b2a_oe_n,
   input  logic             b2a_le,
   input  logic             b2a_clk,
   input  logic             b2a_cken_n,
   output logic [WIDTH-1:0] port_a_o,
   output logic             port_a_drive
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bidir_regxcvr: WIDTH must be at least 1");
      end
   endgenerate

   dir_ctrl_t        ctl  [DIRS];
   logic [WIDTH-1:0] din  [DIRS];
   logic [WIDTH-1:0] dout [DIRS];
   logic             drv  [DIRS];

   assign ctl[DIR_AB] = {a2b_oe_n, a2b_le, a2b_clk, a2b_cken_n};
   assign ctl[DIR_BA] = {b2a_oe_n, b2a_le, b2a_clk, b2a_cken_n};
   assign din[DIR_AB] = port_a_i;
   assign din[DIR_BA] = port_b_i;

   generate
      for (genvar g = 0; g < DIRS; g++) begin : g_dir
         xcvr_dir #(.WIDTH(WIDTH), .EDGE_RISING(EDGE_RISING)) u_dir (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[g]),
            .din   (din[g]),
            .dout  (dout[g]),
            .drive (drv[g])
         );
      end
   endgenerate

   assign port_b_o     = dout[DIR_AB];
   assign port_b_drive = drv[DIR_AB];
   assign port_a_o     = dout[DIR_BA];
   assign port_a_drive = drv[DIR_BA];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
   parameter int WIDTH       = 18,
   parameter bit EDGE_RISING = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] port_a_i,
   input logic             a2b_oe_n,
   input logic             a2b_le,
   input logic             a2b_clk,
   input logic             a2b_cken_n,
   input logic [WIDTH-1:0] port_b_o,
   input logic             port_b_drive,
   input logic [WIDTH-1:0] port_b_i,
   input logic             b2a_oe_n,
   input logic             b2a_le,
   input logic             b2a_clk,
   input logic             b2a_cken_n,
   input logic [WIDTH-1:0] port_a_o,
   input logic             port_a_drive
);
   logic ab_seen, ba_seen;
   logic ab_cap, ba_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_seen <= EDGE_RISING;
         ba_seen <= EDGE_RISING;
      end else begin
         ab_seen <= a2b_clk;
         ba_seen <= b2a_clk;
      end
   end

   assign ab_cap = !a2b_cken_n && (EDGE_RISING ? (a2b_clk && !ab_seen) : (!a2b_clk && ab_seen));
   assign ba_cap = !b2a_cken_n && (EDGE_RISING ? (b2a_clk && !ba_seen) : (!b2a_clk && ba_seen));

   // R2
   ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a2b_le |-> port_b_o == port_a_i);
   // R2
   ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b2a_le |-> port_a_o == port_b_i);
   // R3
   ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a2b_le && !ab_cap) |=> (a2b_le || port_b_o == $past(port_b_o)));
   // R3
   ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b2a_le && !ba_cap) |=> (b2a_le || port_a_o == $past(port_a_o)));
   // R4
   ab_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a2b_le) |-> port_b_o == $past(port_a_i));
   // R4
   ba_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b2a_le) |-> port_a_o == $past(port_b_i));
   // R5
   ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a2b_le && ab_cap) |=> (a2b_le || port_b_o == $past(port_a_i)));
   // R5
   ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b2a_le && ba_cap) |=> (b2a_le || port_a_o == $past(port_b_i)));
   // R8
   ab_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_b_drive == !a2b_oe_n);
   // R8
   ba_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_a_drive == !b2a_oe_n);
endmodule

bind bidir_regxcvr xcvr_chk #(.WIDTH(WIDTH), .EDGE_RISING(EDGE_RISING)) u_chk (.*);

// File: tb/bidir_regxcvr_tb.sv
module bidir_regxcvr_tb;
   localparam int W  = 18;
   localparam int CP = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a_i = '0, b_i = '0;
   logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_ck_n = 1'b1;
   logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_ck_n = 1'b1;
   logic [W-1:0] b_o, a_o;
   logic b_drv, a_drv;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit noted = 0;
   string phase = "R1";

   logic [W-1:0] m_ab, m_ba;
   logic p_ab, p_ba;

   always #(CP/2) clk = ~clk;

   bidir_regxcvr #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .port_a_i(a_i), .a2b_oe_n(ab_oe_n), .a2b_le(ab_le), .a2b_clk(ab_clk), .a2b_cken_n(ab_ck_n),
      .port_b_o(b_o), .port_b_drive(b_drv),
      .port_b_i(b_i), .b2a_oe_n(ba_oe_n), .b2a_le(ba_le), .b2a_clk(ba_clk), .b2a_cken_n(ba_ck_n),
      .port_a_o(a_o), .port_a_drive(a_drv)
   );

   task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("port_b_o", b_o, ab_le ? a_i : m_ab);
      chk("port_b_drive", W'(b_drv), W'(!ab_oe_n));
      chk("port_a_o", a_o, ba_le ? b_i : m_ba);
      chk("port_a_drive", W'(a_drv), W'(!ba_oe_n));
      if (b_drv && a_drv && !noted) begin
         noted = 1;
         $display("note: both ports driven at %0t (bus contention if shared)", $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_ab = '0; m_ba = '0; p_ab = 1; p_ba = 1;
      end else begin
         if (ab_le) m_ab = a_i;
         else if (ab_clk && !p_ab && !ab_ck_n) m_ab = a_i;
         if (ba_le) m_ba = b_i;
         else if (ba_clk && !p_ba && !ba_ck_n) m_ba = b_i;
         p_ab = ab_clk;
         p_ba = ba_clk;
      end
   endtask

   // check settled inputs, take an edge, check again
   task automatic cyc();
      #1 compare();
      @(posedge clk);
      model_edge();
      #1 compare();
   endtask

   initial begin
      m_ab = '0; m_ba = '0; p_ab = 1; p_ba = 1;
      // R1: reset, direction clock already high at release
      ab_clk = 1; ba_clk = 1; ab_ck_n = 0; ba_ck_n = 0;
      a_i = 18'h1A5A5; b_i = 18'h25A5A;
      repeat (3) @(posedge clk);
      #1 compare();
      rst_n = 1;
      cyc(); cyc();

      // R8: output enables
      phase = "R8";
      ab_oe_n = 0; cyc();
      ba_oe_n = 0; ab_oe_n = 1; cyc();
      ab_oe_n = 0; cyc();

      // R2: transparent, data varying
      phase = "R2";
      ab_le = 1; ba_le = 1;
      for (int i = 0; i < 6; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         ab_clk = i[0]; ba_clk = ~i[0];
         cyc();
      end

      // R4: drop latch enable together with new data and a clock change
      phase = "R4";
      ab_clk = 0; ba_clk = 0; cyc();
      a_i = 18'h3FFFF; b_i = 18'h00001; ab_le = 0; ba_le = 0; ab_clk = 1; ba_clk = 1;
      cyc(); cyc();

      // R3: hold with clocks steady
      phase = "R3";
      for (int i = 0; i < 5; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         cyc();
      end

      // R5: clock-enabled captures
      phase = "R5";
      for (int i = 0; i < 8; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         ab_clk = ~ab_clk; ba_clk = ~ba_clk;
         cyc();
      end

      // R6: clock enable inactive on rising edges
      phase = "R6";
      ab_ck_n = 1; ba_ck_n = 1;
      for (int i = 0; i < 6; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         ab_clk = ~ab_clk; ba_clk = ~ba_clk;
         cyc();
      end

      // R7: rise with enable off, fall with enable on
      phase = "R7";
      ab_clk = 0; ba_clk = 0; cyc();
      for (int i = 0; i < 3; i++) begin
         ab_ck_n = 1; ba_ck_n = 1; ab_clk = 1; ba_clk = 1; a_i = W'($urandom); b_i = W'($urandom); cyc();
         ab_ck_n = 0; ba_ck_n = 0; ab_clk = 0; ba_clk = 0; a_i = W'($urandom); b_i = W'($urandom); cyc();
      end

      // R9: capture while not driving, then enable
      phase = "R9";
      ab_oe_n = 1; ba_oe_n = 1;
      a_i = 18'h0BEEF; b_i = 18'h2CAFE; ab_clk = 1; ba_clk = 1; cyc();
      a_i = 18'h11111; b_i = 18'h22222; cyc();
      ab_oe_n = 0; ba_oe_n = 0; cyc();

      // R10: one direction clocked/transparent while the other holds
      phase = "R10";
      ab_clk = 0; ba_clk = 0; cyc();
      for (int i = 0; i < 6; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         ab_clk = ~ab_clk;
         ba_oe_n = i[0];
         cyc();
      end
      ba_le = 1;
      for (int i = 0; i < 4; i++) begin
         a_i = W'($urandom); b_i = W'($urandom);
         ab_oe_n = i[0];
         cyc();
      end

      // R2 priority: latch enable high while clock rises with enable active
      phase = "R2";
      ab_le = 1; ab_ck_n = 0; ab_clk = 0; cyc();
      a_i = 18'h15555; ab_clk = 1; cyc();
      a_i = 18'h0AAAA; ab_le = 0; cyc(); cyc();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CP * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired in %s actual=running expected=finished", phase);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule